// File: doc/BRIEF.md
# DMA Channel Programming Register File

This block is the host-facing register set of a four-channel DMA controller. A host on an 8-bit I/O bus reaches it through a 4-bit register offset, a write strobe, a read strobe and a data byte. For each channel it keeps a 16-bit base and working address and a 16-bit base and working count, plus a six-bit mode. It also keeps a four-bit channel mask, a command byte, a software request set and per-channel terminal-count flags. It presents the working addresses, counts, modes, enables and the command byte to a transfer engine.

Every 16-bit quantity passes through one 8-bit port. A single shared byte pointer chooses the low or the high half and flips after each access. The transfer engine pulses one step line per channel for each transfer it completes. The block then moves the working address and count, flags terminal count, and reloads the working copies from the base copies when auto-initialise is set.

Top module: `dma_regfile`

## Requirements
- R1: After reset every mask bit is 1, the command byte, software requests and terminal-count flags are 0, the byte pointer selects the low byte, and all addresses, counts and modes are 0, so `chan_en` is 0000.
- R2: Offset 2n (n = 0..3) is channel n's address port and offset 2n+1 its count port. A write puts the byte chosen by the pointer into both the base and the working copy. A read with `reg_rd` returns that byte of the working copy. Reads of offsets 0x9 to 0xF, and `reg_rdata` while `reg_rd` is low, give 0x00.
- R3: The byte pointer selects the low byte first and the high byte next. It toggles on every read or write of offsets 0x0 to 0x7, and a write of any value to offset 0xC sets it back to low.
- R4: A write to offset 0xA uses data bits 1:0 as the channel and sets that channel's mask bit if data bit 2 is 1, else clears it. A write to 0xE clears all mask bits. A write to 0xF loads mask bits 3:0 from data bits 3:0.
- R5: A write to offset 0xB stores data bits 7:2 as the mode of the channel in data bits 1:0 (mode bit 3 = decrement, bit 2 = auto-initialise, bits 5:4 = 11 cascade). `chan_cascade[n]` is 1 exactly when channel n's mode bits 5:4 are 11.
- R6: A write to offset 0x8 loads the command byte. `chan_en[n]` is 1 exactly when mask bit n is 0 and command bit 2 (controller disable) is 0.
- R7: A read of offset 0x8 returns terminal-count flags in bits 3:0 and pending requests (software request OR `hw_req`) in bits 7:4. The read clears the terminal-count flags, except for a flag set in that same cycle.
- R8: A write to offset 0x9 uses data bits 1:0 as the channel and sets that channel's software request if data bit 2 is 1, else clears it.
- R9: A write of any value to offset 0xD sets all mask bits, clears the command byte, software requests and terminal-count flags, and returns the pointer to low. Addresses, counts and modes are kept.
- R10: A step on channel n decrements its working count and moves its working address by +1, or by -1 when mode bit 3 is 1. A step while the count is 0 sets terminal-count flag n. With auto-initialise it reloads both working copies from the base copies; without it the count wraps to 0xFFFF.
- R11: If the host writes a channel's address or count port in the same cycle as a step on that channel, the write wins for that register and the step is dropped for it alone. A step dropped from the count raises no terminal count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register offset |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Read data byte (combinational) |
| xfer_step | input | 4 | Per-channel transfer-complete pulse from the engine |
| hw_req | input | 4 | Per-channel hardware request level |
| cur_addr | output | 64 | Working addresses, channel n at bits 16n+15:16n |
| cur_count | output | 64 | Working counts, channel n at bits 16n+15:16n |
| chan_mode | output | 24 | Modes, channel n at bits 6n+5:6n |
| chan_en | output | 4 | Channel enables |
| chan_cascade | output | 4 | Channel in cascade mode |
| cmd_out | output | 8 | Command byte |

## Verification
The hardest situation to reach from the ports is a transfer step that lands in the same cycle as a host access to the same channel. Examples are a count-byte write racing a step at count zero, or a status read in the cycle a terminal count rises. The stimulus reaches these cases in two ways. Directed sequences line the count up at zero and then issue the write with the step. Random traffic drives step pulses on a third of all bus cycles, so collisions with port writes, pointer flips and status reads happen often and are each compared against the bench's reference model.

// File: rtl/dma_regfile_pkg.sv
package dma_regfile_pkg;

  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int MODE_W = 6;

  // register offsets whose position the host software depends on
  localparam logic [3:0] OFS_CMD     = 4'h8;
  localparam logic [3:0] OFS_SREQ    = 4'h9;
  localparam logic [3:0] OFS_SMASK   = 4'hA;
  localparam logic [3:0] OFS_MODE    = 4'hB;
  localparam logic [3:0] OFS_CLRPTR  = 4'hC;
  localparam logic [3:0] OFS_MCLR    = 4'hD;
  localparam logic [3:0] OFS_CLRMASK = 4'hE;
  localparam logic [3:0] OFS_AMASK   = 4'hF;

  localparam logic [1:0] KIND_CASCADE = 2'b11;

  // stored mode = write byte bits 7:2
  typedef struct packed {
    logic [1:0] kind;       // transfer kind, 11 = cascade
    logic       down;       // address decrements
    logic       auto_init;  // reload at terminal count
    logic [1:0] xdir;       // direction / verify selection
  } mode_t;

  function automatic logic [WORD_W-1:0] put_byte(
    input logic [WORD_W-1:0] word,
    input logic              hi,
    input logic [BYTE_W-1:0] b
  );
    put_byte = hi ? {b, word[BYTE_W-1:0]} : {word[WORD_W-1:BYTE_W], b};
  endfunction

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regfile_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_wr,
  input  logic              cnt_wr,
  input  logic              byte_hi,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              mode_wr,
  input  mode_t             mode_in,
  input  logic              step,
  output logic [WORD_W-1:0] cur_addr,
  output logic [WORD_W-1:0] cur_cnt,
  output mode_t             mode,
  output logic              tc
);

  logic [WORD_W-1:0] base_addr_q, base_addr_d, cur_addr_q, cur_addr_d;
  logic [WORD_W-1:0] base_cnt_q, base_cnt_d, cur_cnt_q, cur_cnt_d;
  mode_t             mode_q, mode_d;
  logic              reload;

  always_comb begin
    base_addr_d = base_addr_q;
    cur_addr_d  = cur_addr_q;
    base_cnt_d  = base_cnt_q;
    cur_cnt_d   = cur_cnt_q;
    mode_d      = mode_q;
    tc          = step & ~cnt_wr & (cur_cnt_q == '0);
    reload      = tc & mode_q.auto_init;

    if (cnt_wr) begin
      base_cnt_d = put_byte(base_cnt_q, byte_hi, wdata);
      cur_cnt_d  = put_byte(cur_cnt_q, byte_hi, wdata);
    end else if (step) begin
      cur_cnt_d = reload ? base_cnt_q : cur_cnt_q - 1'b1;
    end

    if (addr_wr) begin
      base_addr_d = put_byte(base_addr_q, byte_hi, wdata);
      cur_addr_d  = put_byte(cur_addr_q, byte_hi, wdata);
    end else if (step) begin
      if (reload)           cur_addr_d = base_addr_q;
      else if (mode_q.down) cur_addr_d = cur_addr_q - 1'b1;
      else                  cur_addr_d = cur_addr_q + 1'b1;
    end

    if (mode_wr) mode_d = mode_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_addr_q <= '0;
      cur_addr_q  <= '0;
      base_cnt_q  <= '0;
      cur_cnt_q   <= '0;
      mode_q      <= '0;
    end else begin
      base_addr_q <= base_addr_d;
      cur_addr_q  <= cur_addr_d;
      base_cnt_q  <= base_cnt_d;
      cur_cnt_q   <= cur_cnt_d;
      mode_q      <= mode_d;
    end
  end

  assign cur_addr = cur_addr_q;
  assign cur_cnt  = cur_cnt_q;
  assign mode     = mode_q;

  // R10
  cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !cnt_wr && cur_cnt_q != '0) |=> cur_cnt_q == WORD_W'($past(cur_cnt_q) - 1'b1));

  // R10
  tc_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !cnt_wr && !addr_wr && cur_cnt_q == '0 && mode_q.auto_init)
      |=> (cur_cnt_q == $past(base_cnt_q) && cur_addr_q == $past(base_addr_q)));

endmodule

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs
  import dma_regfile_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mclr,
  input  logic              cmd_wr,
  input  logic              req_wr,
  input  logic              smask_wr,
  input  logic              amask_wr,
  input  logic              clrmask_wr,
  input  logic              stat_rd,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [NCH-1:0]    tc_set,
  input  logic [NCH-1:0]    hw_req,
  output logic [NCH-1:0]    mask,
  output logic [BYTE_W-1:0] cmd,
  output logic [2*NCH-1:0]  status
);

  localparam int CHW = $clog2(NCH);

  logic [NCH-1:0]    mask_q, mask_d, sreq_q, sreq_d, tc_q, tc_d;
  logic [BYTE_W-1:0] cmd_q, cmd_d;

  always_comb begin
    mask_d = mask_q;
    sreq_d = sreq_q;
    cmd_d  = cmd_q;
    tc_d   = (stat_rd ? '0 : tc_q) | tc_set;
    if (mclr) begin
      mask_d = '1;
      sreq_d = '0;
      cmd_d  = '0;
      tc_d   = '0;
    end else begin
      if (clrmask_wr)    mask_d = '0;
      else if (amask_wr) mask_d = wdata[NCH-1:0];
      else if (smask_wr) mask_d[wdata[CHW-1:0]] = wdata[2];
      if (req_wr) sreq_d[wdata[CHW-1:0]] = wdata[2];
      if (cmd_wr) cmd_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      sreq_q <= '0;
      cmd_q  <= '0;
      tc_q   <= '0;
    end else begin
      mask_q <= mask_d;
      sreq_q <= sreq_d;
      cmd_q  <= cmd_d;
      tc_q   <= tc_d;
    end
  end

  assign mask   = mask_q;
  assign cmd    = cmd_q;
  assign status = {sreq_q | hw_req, tc_q};

  // R9
  mclr_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mclr |=> (mask_q == '1 && cmd_q == '0 && sreq_q == '0 && tc_q == '0));

  // R7
  tc_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|tc_set && !mclr) |=> ((tc_q & $past(tc_set)) == $past(tc_set)));

  // R7
  tc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && tc_set == '0) |=> tc_q == '0);

endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
  import dma_regfile_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [3:0]            reg_addr,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [BYTE_W-1:0]     reg_wdata,
  output logic [BYTE_W-1:0]     reg_rdata,
  input  logic [NCH-1:0]        xfer_step,
  input  logic [NCH-1:0]        hw_req,
  output logic [NCH*WORD_W-1:0] cur_addr,
  output logic [NCH*WORD_W-1:0] cur_count,
  output logic [NCH*MODE_W-1:0] chan_mode,
  output logic [NCH-1:0]        chan_en,
  output logic [NCH-1:0]        chan_cascade,
  output logic [BYTE_W-1:0]     cmd_out
);

  localparam int CHW = $clog2(NCH);

  logic              rd_fire, acc16, wr16, mclr, ptr_q, ptr_d;
  logic [CHW-1:0]    port_ch;
  logic [WORD_W-1:0] ca [NCH];
  logic [WORD_W-1:0] cc [NCH];
  mode_t             md [NCH];
  logic [NCH-1:0]    tc_set, mask;
  logic [2*NCH-1:0]  status;
  logic [WORD_W-1:0] rd_word;

  assign rd_fire = reg_rd & ~reg_wr;
  assign wr16    = reg_wr & ~reg_addr[3];
  assign acc16   = (reg_wr | rd_fire) & ~reg_addr[3];
  assign mclr    = reg_wr & (reg_addr == OFS_MCLR);
  assign port_ch = reg_addr[CHW:1];

  always_comb begin
    ptr_d = ptr_q;
    if (mclr || (reg_wr && reg_addr == OFS_CLRPTR)) ptr_d = 1'b0;
    else if (acc16)                                  ptr_d = ~ptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= 1'b0;
    else        ptr_q <= ptr_d;
  end

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    dma_chan_regs u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr_wr  (wr16 && port_ch == CHW'(n) && !reg_addr[0]),
      .cnt_wr   (wr16 && port_ch == CHW'(n) && reg_addr[0]),
      .byte_hi  (ptr_q),
      .wdata    (reg_wdata),
      .mode_wr  (reg_wr && reg_addr == OFS_MODE && reg_wdata[CHW-1:0] == CHW'(n)),
      .mode_in  (mode_t'(reg_wdata[BYTE_W-1:BYTE_W-MODE_W])),
      .step     (xfer_step[n]),
      .cur_addr (ca[n]),
      .cur_cnt  (cc[n]),
      .mode     (md[n]),
      .tc       (tc_set[n])
    );
    assign cur_addr[n*WORD_W +: WORD_W]  = ca[n];
    assign cur_count[n*WORD_W +: WORD_W] = cc[n];
    assign chan_mode[n*MODE_W +: MODE_W] = md[n];
    assign chan_cascade[n]               = (md[n].kind == KIND_CASCADE);
  end

  dma_ctrl_regs #(.NCH(NCH)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .mclr       (mclr),
    .cmd_wr     (reg_wr && reg_addr == OFS_CMD),
    .req_wr     (reg_wr && reg_addr == OFS_SREQ),
    .smask_wr   (reg_wr && reg_addr == OFS_SMASK),
    .amask_wr   (reg_wr && reg_addr == OFS_AMASK),
    .clrmask_wr (reg_wr && reg_addr == OFS_CLRMASK),
    .stat_rd    (rd_fire && reg_addr == OFS_CMD),
    .wdata      (reg_wdata),
    .tc_set     (tc_set),
    .hw_req     (hw_req),
    .mask       (mask),
    .cmd        (cmd_out),
    .status     (status)
  );

  assign chan_en = ~mask & {NCH{~cmd_out[2]}};

  always_comb begin
    rd_word   = reg_addr[0] ? cc[port_ch] : ca[port_ch];
    reg_rdata = '0;
    if (reg_rd) begin
      if (!reg_addr[3])              reg_rdata = ptr_q ? rd_word[WORD_W-1:BYTE_W] : rd_word[BYTE_W-1:0];
      else if (reg_addr == OFS_CMD)  reg_rdata = BYTE_W'(status);
    end
  end

  // R3
  ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_CLRPTR) |=> !ptr_q);

  // R3
  ptr_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && !reg_addr[3]) |=> ptr_q != $past(ptr_q));

endmodule

// File: tb/tb_dma_regfile.sv
module tb_dma_regfile;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  reg_addr;
  logic        reg_wr, reg_rd;
  logic [7:0]  reg_wdata, reg_rdata;
  logic [3:0]  xfer_step, hw_req;
  logic [63:0] cur_addr, cur_count;
  logic [23:0] chan_mode;
  logic [3:0]  chan_en, chan_cascade;
  logic [7:0]  cmd_out;

  dma_regfile dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int nchk = 0, nfail = 0;
  bit done = 0;

  // reference model
  logic [15:0] m_ba[4], m_ca[4], m_bc[4], m_cc[4];
  logic [5:0]  m_md[4];
  logic [3:0]  m_mask, m_sreq, m_tc;
  logic [7:0]  m_cmd;
  logic        m_ptr;

  function automatic logic [15:0] pb(input logic [15:0] w, input logic hi, input logic [7:0] b);
    pb = hi ? {b, w[7:0]} : {w[15:8], b};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int n = 0; n < 4; n++) begin
      m_ba[n] = 0; m_ca[n] = 0; m_bc[n] = 0; m_cc[n] = 0; m_md[n] = 0;
    end
    m_mask = 4'hF; m_sreq = 0; m_tc = 0; m_cmd = 0; m_ptr = 0;
  endtask

  function automatic logic [7:0] exp_rdata(input logic [3:0] a);
    logic [15:0] w;
    if (a < 8) begin
      w = a[0] ? m_cc[a[2:1]] : m_ca[a[2:1]];
      return m_ptr ? w[15:8] : w[7:0];
    end
    if (a == 4'h8) return {m_sreq | hw_req, m_tc};
    return 8'h00;
  endfunction

  task automatic model_clock(input logic [3:0] a, input logic w, input logic r,
                             input logic [7:0] d, input logic [3:0] s);
    logic [3:0] tcn;
    logic aw, cw, tcb;
    tcn = 0;
    for (int n = 0; n < 4; n++) begin
      aw  = w && a < 8 && a[2:1] == n[1:0] && !a[0];
      cw  = w && a < 8 && a[2:1] == n[1:0] && a[0];
      tcb = s[n] && !cw && m_cc[n] == 0;
      tcn[n] = tcb;
      if (aw) begin
        m_ca[n] = pb(m_ca[n], m_ptr, d); m_ba[n] = pb(m_ba[n], m_ptr, d);
      end else if (s[n]) begin
        if (tcb && m_md[n][2]) m_ca[n] = m_ba[n];
        else if (m_md[n][3])   m_ca[n] = m_ca[n] - 1;
        else                   m_ca[n] = m_ca[n] + 1;
      end
      if (cw) begin
        m_cc[n] = pb(m_cc[n], m_ptr, d); m_bc[n] = pb(m_bc[n], m_ptr, d);
      end else if (s[n]) begin
        m_cc[n] = (tcb && m_md[n][2]) ? m_bc[n] : m_cc[n] - 1;
      end
    end
    if (w && a == 4'hD) begin
      m_mask = 4'hF; m_sreq = 0; m_tc = 0; m_cmd = 0; m_ptr = 0;
    end else begin
      m_tc = ((r && !w && a == 4'h8) ? 4'h0 : m_tc) | tcn;
      if (w && a == 4'hC) m_ptr = 0;
      else if ((w || r) && a < 8) m_ptr = ~m_ptr;
      if (w && a == 4'h8) m_cmd = d;
      if (w && a == 4'h9) m_sreq[d[1:0]] = d[2];
      if (w && a == 4'hA) m_mask[d[1:0]] = d[2];
      if (w && a == 4'hE) m_mask = 0;
      if (w && a == 4'hF) m_mask = d[3:0];
      if (w && a == 4'hB) m_md[d[1:0]] = d[7:2];
    end
  endtask

  task automatic check_outputs(input string tag);
    logic [3:0] casc;
    for (int n = 0; n < 4; n++) casc[n] = (m_md[n][5:4] == 2'b11);
    chk({tag, " R10 cur_addr"}, cur_addr, {m_ca[3], m_ca[2], m_ca[1], m_ca[0]});
    chk({tag, " R10 cur_count"}, cur_count, {m_cc[3], m_cc[2], m_cc[1], m_cc[0]});
    chk({tag, " R5 chan_mode"}, chan_mode, {m_md[3], m_md[2], m_md[1], m_md[0]});
    chk({tag, " R5 chan_cascade"}, chan_cascade, casc);
    chk({tag, " R6 chan_en"}, chan_en, ~m_mask & {4{~m_cmd[2]}});
    chk({tag, " R6 cmd_out"}, cmd_out, m_cmd);
  endtask

  task automatic do_op(input string tag, input logic [3:0] a, input logic w, input logic r,
                       input logic [7:0] d, input logic [3:0] s);
    @(negedge clk);
    reg_addr = a; reg_wr = w; reg_rd = r; reg_wdata = d; xfer_step = s;
    #1;
    chk({tag, (a == 4'h8) ? " R7 status" : " R2 rdata"}, reg_rdata, r ? exp_rdata(a) : 8'h00);
    @(posedge clk);
    #1;
    reg_wr = 0; reg_rd = 0; xfer_step = 0;
    model_clock(a, w, r, d, s);
    #1;
    check_outputs(tag);
  endtask

  task automatic wr(input string tag, input logic [3:0] a, input logic [7:0] d);
    do_op(tag, a, 1, 0, d, 4'h0);
  endtask
  task automatic rd(input string tag, input logic [3:0] a);
    do_op(tag, a, 0, 1, 8'h00, 4'h0);
  endtask
  task automatic stp(input string tag, input logic [3:0] s);
    do_op(tag, 4'h0, 0, 0, 8'h00, s);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240917));
    rst_n = 0; reg_addr = 0; reg_wr = 0; reg_rd = 0; reg_wdata = 0; xfer_step = 0; hw_req = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check_outputs("R1 reset");
    rd("R1 reset status", 4'h8);
    rd("R1 reset ptr low", 4'h2);
    wr("R3 clear ptr", 4'hC, 8'h5A);

    // R2 R3: channel 1 address 0x1234, count 0x0002
    wr("R2 addr lo", 4'h2, 8'h34);
    wr("R2 addr hi", 4'h2, 8'h12);
    rd("R3 read lo", 4'h2);
    rd("R3 read hi", 4'h2);
    wr("R2 cnt lo", 4'h3, 8'h02);
    wr("R3 clear mid", 4'hC, 8'h00);
    wr("R2 cnt lo again", 4'h3, 8'h02);
    wr("R2 cnt hi", 4'h3, 8'h00);
    rd("R2 offset E", 4'hE);
    wr("R5 mode ch1 0x44", 4'hB, 8'h45);
    wr("R4 clear all masks", 4'hE, 8'h00);
    // R10 non-auto: 2,1,0 then wrap
    stp("R10 step1", 4'b0010);
    stp("R10 step2", 4'b0010);
    stp("R10 step3 tc", 4'b0010);
    rd("R7 tc seen", 4'h8);
    rd("R7 tc cleared", 4'h8);

    // R10 auto-initialise on channel 2
    wr("R5 mode ch2 auto", 4'hB, 8'h52);
    wr("R2 ch2 addr lo", 4'h4, 8'hFF);
    wr("R2 ch2 addr hi", 4'h4, 8'h00);
    wr("R2 ch2 cnt lo", 4'h5, 8'h01);
    wr("R2 ch2 cnt hi", 4'h5, 8'h00);
    stp("R10 auto step1", 4'b0100);
    stp("R10 auto reload", 4'b0100);
    // R10 decrement on channel 3
    wr("R5 mode ch3 down", 4'hB, 8'h2B);
    stp("R10 decrement", 4'b1000);
    // R5 cascade
    wr("R5 cascade ch0", 4'hB, 8'hC0);
    // R6
    wr("R6 disable", 4'h8, 8'h04);
    wr("R6 enable", 4'h8, 8'h00);
    // R8
    hw_req = 4'b0001;
    wr("R8 set sreq ch2", 4'h9, 8'h06);
    rd("R8 status req", 4'h8);
    wr("R8 clear sreq ch2", 4'h9, 8'h02);
    rd("R8 status req clr", 4'h8);
    hw_req = 0;
    // R11 collision: count write with step at count zero
    wr("R11 prep cnt lo", 4'h5, 8'h00);
    wr("R11 prep cnt hi", 4'h5, 8'h00);
    do_op("R11 write beats step", 4'h5, 1, 0, 8'h07, 4'b0100);
    rd("R11 no tc", 4'h8);
    do_op("R11 addr write with step", 4'h4, 1, 0, 8'h33, 4'b0100);
    // R7 status read in the cycle a tc rises
    wr("R7 ptr", 4'hC, 8'h00);
    wr("R7 cnt lo", 4'h7, 8'h00);
    wr("R7 cnt hi", 4'h7, 8'h00);
    do_op("R7 read with tc", 4'h8, 0, 1, 8'h00, 4'b1000);
    rd("R7 tc kept", 4'h8);
    // R4 single and all mask
    wr("R4 set ch1", 4'hA, 8'h05);
    wr("R4 clear ch1", 4'hA, 8'h01);
    wr("R4 load all", 4'hF, 8'h03);
    // R9 master clear from pointer high
    wr("R9 cmd", 4'h8, 8'h10);
    rd("R9 ptr move", 4'h0);
    wr("R9 master clear", 4'hD, 8'h00);
    rd("R9 ptr low", 4'h2);
    rd("R9 status", 4'h8);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] a, s;
      logic [7:0] d;
      int k;
      k = $urandom % 10;
      d = 8'($urandom);
      s = ($urandom % 3 == 0) ? 4'($urandom) : 4'h0;
      hw_req = 4'($urandom);
      case (k)
        0, 1, 2, 3: do_op("rnd write16", 4'($urandom % 8), 1, 0, d, s);
        4, 5:       do_op("rnd read16", 4'($urandom % 8), 0, 1, d, s);
        6:          do_op("rnd status", 4'h8, 0, 1, d, s);
        7: begin
          a = 4'(9 + ($urandom % 7));
          if (a == 4'hD || a == 4'hC) a = 4'hB;
          do_op("rnd ctrl", a, 1, 0, d, s);
        end
        8:          do_op("rnd idle", 4'h0, 0, 0, d, s);
        default:    do_op("rnd clear", ($urandom % 8 == 0) ? 4'hD : 4'hC, 1, 0, d, s);
      endcase
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule